// File: doc/BRIEF.md
# Serial Memory Power, Sleep and Hold Sequencer

This block governs when a serial memory is allowed to respond on its SPI pins. It runs on a free-running system clock. After power-good rises it holds a start-up lockout. It then runs normally until a decoded sleep strobe arrives. At that point it runs a short entry interval, after which the regulators are reported off. A decoded wake strobe starts a long recovery lockout, and normal service returns only when that lockout ends. During both lockouts the chip select is not passed on, and a host that drops the chip select in a lockout is recorded in a sticky fault flag.

The block also applies the hold function. While a transaction is open and the hold input is low, the forwarded chip select and serial clock are frozen, the transfer logic is told to pause, and the serial output driver is forced to high impedance. When hold is released, the frozen clock level is where the transfer resumes, so no bit is lost or repeated. The SPI controller downstream runs on the forwarded chip select and clock. It uses the command-lock output to refuse everything except the wake command while the memory sleeps.

All inputs are assumed to be synchronous to the system clock. Lockout lengths are parameters in microseconds, and a separate parameter gives the clock cycles per microsecond.

Top module: `pwr_hold_seq`

## Requirements
- R1: While reset is applied, or while power-good has never been high, bus_en=0, regs_on=0, cmd_lock=0, cs_fwd_n=1, so_hiz=1 and fault=0.
- R2: When power-good is first sampled high in the off state, a start-up lockout of BOOT_US*CYC_PER_US cycles follows with bus_en=0. bus_en rises on the cycle after it ends.
- R3: A chip-select fall (cs_n sampled 1 then 0) during the start-up lockout or the wake recovery sets fault. The fall is not forwarded, so cs_fwd_n stays 1. fault stays set until reset, including across a power loss.
- R4: A sleep strobe in the running state starts an entry interval of DOZE_US*CYC_PER_US cycles. During it, cmd_lock=1 and regs_on=1. After it, regs_on=0.
- R5: Strobes that do not match the state have no effect. A sleep strobe outside the running state is ignored, and a wake strobe is ignored unless the block is in sleep entry or in sleep.
- R6: A wake strobe in sleep entry or in sleep starts a recovery of WAKE_US*CYC_PER_US cycles. During it, regs_on=1, bus_en=0 and cs_fwd_n=1. Running resumes afterwards.
- R7: While cs_fwd_n=0 and hold_n=0, xfer_pause=1 and so_hiz=1. cs_fwd_n and sck_fwd keep their values even if cs_n or sck change.
- R8: hold_n low while cs_fwd_n=1 has no effect. xfer_pause stays 0.
- R9: Outside a pause, sck_fwd equals sck delayed by one clock. After hold is released, sck_fwd resumes from its frozen level.
- R10: A chip select that is already low when access opens is not forwarded. cs_fwd_n falls only on a 1-to-0 change of cs_n while access is open.
- R11: power-good sampled low forces the off state on the next cycle from any state, which gives bus_en=0, regs_on=0 and cs_fwd_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply is within range |
| cs_n | input | 1 | Raw chip select from the host, active low |
| sck | input | 1 | Raw serial clock, sampled |
| hold_n | input | 1 | Hold request, active low |
| sleep_cmd | input | 1 | One-cycle strobe: sleep command decoded |
| wake_cmd | input | 1 | One-cycle strobe: wake command decoded |
| bus_en | output | 1 | Memory may take part in transactions |
| cmd_lock | output | 1 | Only the wake command may be honoured |
| cs_fwd_n | output | 1 | Chip select forwarded to the SPI controller |
| sck_fwd | output | 1 | Serial clock forwarded to the SPI controller |
| xfer_pause | output | 1 | Transaction is paused by hold |
| so_hiz | output | 1 | Force the serial output to high impedance |
| regs_on | output | 1 | Internal regulators are reported on |
| fault | output | 1 | Sticky: chip select dropped during a lockout |

## Verification
The sequencer is driven through power-up with the chip select parked low across the end of the lockout, which separates true edge detection from level following. It is then driven through a sleep that completes, a wake from completed sleep with a chip-select drop during recovery, and a wake issued during sleep entry, which show whether the state machine honours the wake strobe early. Hold is applied inside a live transfer while the clock and chip select keep moving, which exposes any leak through the freeze. Hold is also applied outside a transfer to show that it is ignored there. Power is removed mid-transfer, and the fault is then raised in the start-up lockout after a fresh reset.

// File: rtl/pwrseq_pkg.sv
// Shared types for the power/sleep/hold sequencer.
package pwrseq_pkg;
    typedef enum logic [2:0] {
        PS_OFF     = 3'd0,
        PS_BOOT    = 3'd1,
        PS_RUN     = 3'd2,
        PS_DOZE_IN = 3'd3,
        PS_DOZE    = 3'd4,
        PS_WAKE    = 3'd5
    } pstate_e;
endpackage

// File: rtl/pwrseq_timer.sv
// Lockout down-counter. Load has priority. While run is high the count
// decrements to zero, and expire flags the last cycle of the interval.
// Assumes load values are at least zero, so a loaded N-1 gives N cycles.
module pwrseq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Count register: load, decrement, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = run && (cnt == '0);

    // R2
    tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pwrseq_fsm.sv
// Accessibility state machine: off, start-up lockout, running, sleep entry,
// sleep, wake recovery. Assumes command strobes are single-cycle and that
// pwr_good is synchronous. Outputs are decodes of the state register, plus
// acc_nxt, which tells the bus gate whether access is open next cycle.
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BOOT_CYC = 400,
    parameter int DOZE_CYC = 3,
    parameter int WAKE_CYC = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             sleep_cmd,
    input  logic             wake_cmd,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tmr_run,
    output logic             bus_en,
    output logic             cmd_lock,
    output logic             regs_on,
    output logic             locked,
    output logic             acc_nxt
);
    localparam logic [CNT_W-1:0] BOOT_LD = CNT_W'(BOOT_CYC - 1);
    localparam logic [CNT_W-1:0] DOZE_LD = CNT_W'(DOZE_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYC - 1);

    pstate_e state, nxt;

    // Next-state and timer-load decision.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!pwr_good) begin
            nxt = PS_OFF;
        end else begin
            unique case (state)
                PS_OFF: begin
                    nxt = PS_BOOT; tmr_load = 1'b1; tmr_val = BOOT_LD;
                end
                PS_BOOT:    if (tmr_done) nxt = PS_RUN;
                PS_RUN: if (sleep_cmd) begin
                    nxt = PS_DOZE_IN; tmr_load = 1'b1; tmr_val = DOZE_LD;
                end
                PS_DOZE_IN: if (wake_cmd) begin
                    nxt = PS_WAKE; tmr_load = 1'b1; tmr_val = WAKE_LD;
                end else if (tmr_done) begin
                    nxt = PS_DOZE;
                end
                PS_DOZE: if (wake_cmd) begin
                    nxt = PS_WAKE; tmr_load = 1'b1; tmr_val = WAKE_LD;
                end
                PS_WAKE:    if (tmr_done) nxt = PS_RUN;
                default:    nxt = PS_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_OFF;
        else        state <= nxt;
    end

    assign tmr_run  = (state == PS_BOOT) || (state == PS_DOZE_IN) || (state == PS_WAKE);
    assign bus_en   = (state == PS_RUN) || (state == PS_DOZE_IN) || (state == PS_DOZE);
    assign cmd_lock = (state == PS_DOZE_IN) || (state == PS_DOZE);
    assign regs_on  = (state != PS_OFF) && (state != PS_DOZE);
    assign locked   = (state == PS_BOOT) || (state == PS_WAKE);
    assign acc_nxt  = (nxt == PS_RUN) || (nxt == PS_DOZE_IN) || (nxt == PS_DOZE);

    // R2
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_en) |-> ($past(state) == PS_BOOT || $past(state) == PS_WAKE));
    // R4
    doze_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(regs_on) && $past(pwr_good)) |-> ($past(state) == PS_DOZE_IN));
    // R11
    power_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (state == PS_OFF));
endmodule

// File: rtl/pwrseq_gate.sv
// Bus gate: forwards the chip select and serial clock to the SPI controller.
// It blocks the chip select while access is closed and freezes both signals
// while hold is active inside a transaction. It also records chip-select
// falls during lockouts. Assumes cs_n, sck and hold_n are synchronous.
module pwrseq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    input  logic acc_nxt,
    input  logic locked,
    output logic cs_fwd_n,
    output logic sck_fwd,
    output logic xfer_pause,
    output logic fault
);
    logic cs_q, cs_raw_q, sck_q;
    logic cs_fall;

    assign xfer_pause = !hold_n && !cs_q;
    assign cs_fall    = cs_raw_q && !cs_n;

    // Forwarded chip select: closed, frozen, released, or opened on a true fall.
    always_ff @(posedge clk) begin
        if (!rst_n)           cs_q <= 1'b1;
        else if (!acc_nxt)    cs_q <= 1'b1;
        else if (xfer_pause)  cs_q <= cs_q;
        else if (cs_n)        cs_q <= 1'b1;
        else if (cs_fall)     cs_q <= 1'b0;
    end

    // Raw chip-select history and forwarded clock (held during a pause).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_raw_q <= 1'b1;
            sck_q    <= 1'b0;
        end else begin
            cs_raw_q <= cs_n;
            if (!xfer_pause) sck_q <= sck;
        end
    end

    // Sticky lockout-violation flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                 fault <= 1'b0;
        else if (locked && cs_fall) fault <= 1'b1;
    end

    assign cs_fwd_n = cs_q;
    assign sck_fwd  = sck_q;

    // R3
    sticky_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
    // R3
    lockout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_nxt |=> cs_fwd_n);
    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_pause && acc_nxt) |=> ($stable(sck_fwd) && $stable(cs_fwd_n)));
endmodule

// File: rtl/pwr_hold_seq.sv
// Top of the power, sleep and hold sequencer. It converts lockout lengths
// from microseconds to clock cycles and ties together the state machine,
// the lockout timer and the bus gate. Assumes all inputs are synchronous
// to clk and that every lockout length is at least one cycle.
module pwr_hold_seq #(
    parameter int CYC_PER_US = 100,
    parameter int BOOT_US    = 400,
    parameter int DOZE_US    = 3,
    parameter int WAKE_US    = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    input  logic sleep_cmd,
    input  logic wake_cmd,
    output logic bus_en,
    output logic cmd_lock,
    output logic cs_fwd_n,
    output logic sck_fwd,
    output logic xfer_pause,
    output logic so_hiz,
    output logic regs_on,
    output logic fault
);
    localparam int BOOT_CYC = BOOT_US * CYC_PER_US;
    localparam int DOZE_CYC = DOZE_US * CYC_PER_US;
    localparam int WAKE_CYC = WAKE_US * CYC_PER_US;
    localparam int MAX_BW   = (BOOT_CYC > WAKE_CYC) ? BOOT_CYC : WAKE_CYC;
    localparam int MAX_CYC  = (MAX_BW > DOZE_CYC) ? MAX_BW : DOZE_CYC;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic             tmr_load, tmr_run, tmr_done, locked, acc_nxt;
    logic [CNT_W-1:0] tmr_val;

    pwrseq_fsm #(
        .CNT_W(CNT_W), .BOOT_CYC(BOOT_CYC), .DOZE_CYC(DOZE_CYC), .WAKE_CYC(WAKE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .sleep_cmd(sleep_cmd), .wake_cmd(wake_cmd), .tmr_done(tmr_done),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_run(tmr_run),
        .bus_en(bus_en), .cmd_lock(cmd_lock), .regs_on(regs_on),
        .locked(locked), .acc_nxt(acc_nxt)
    );

    pwrseq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .run(tmr_run), .expire(tmr_done)
    );

    pwrseq_gate u_gate (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .acc_nxt(acc_nxt), .locked(locked), .cs_fwd_n(cs_fwd_n),
        .sck_fwd(sck_fwd), .xfer_pause(xfer_pause), .fault(fault)
    );

    assign so_hiz = xfer_pause || cs_fwd_n;
endmodule

// File: tb/pwr_hold_seq_test.sv
// Bench for pwr_hold_seq: a behavioural per-cycle model compared on every
// clock, plus directed checks at the points the requirements name.
module pwr_hold_seq_test;
    localparam int CPU  = 2;
    localparam int BOOT = 400 * CPU;
    localparam int DOZE = 3 * CPU;
    localparam int WAKE = 400 * CPU;

    logic clk = 1'b0;
    logic rst_n, pwr_good, cs_n, sck, hold_n, sleep_cmd, wake_cmd;
    logic bus_en, cmd_lock, cs_fwd_n, sck_fwd, xfer_pause, so_hiz, regs_on, fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pwr_hold_seq #(.CYC_PER_US(CPU), .BOOT_US(400), .DOZE_US(3), .WAKE_US(400)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs_n(cs_n), .sck(sck),
        .hold_n(hold_n), .sleep_cmd(sleep_cmd), .wake_cmd(wake_cmd),
        .bus_en(bus_en), .cmd_lock(cmd_lock), .cs_fwd_n(cs_fwd_n),
        .sck_fwd(sck_fwd), .xfer_pause(xfer_pause), .so_hiz(so_hiz),
        .regs_on(regs_on), .fault(fault)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: 0 off, 1 boot, 2 run, 3 entering sleep, 4 sleep, 5 waking.
    int m_st = 0, m_left = 0;
    bit m_csq = 1, m_raw = 1, m_sck = 0, m_fault = 0, m_ok = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_csq = 1; m_raw = 1; m_sck = 0; m_fault = 0; m_ok = 1;
        end else begin
            int  ns, nl;
            bit  p, acc;
            p  = !hold_n && !m_csq;
            ns = m_st;
            nl = (m_left > 0) ? m_left - 1 : 0;
            if (!pwr_good) ns = 0;
            else if (m_st == 0) begin ns = 1; nl = BOOT - 1; end
            else if (m_st == 1 && m_left == 0) ns = 2;
            else if (m_st == 2 && sleep_cmd) begin ns = 3; nl = DOZE - 1; end
            else if ((m_st == 3 || m_st == 4) && wake_cmd) begin ns = 5; nl = WAKE - 1; end
            else if (m_st == 3 && m_left == 0) ns = 4;
            else if (m_st == 5 && m_left == 0) ns = 2;
            acc = (ns >= 2 && ns <= 4);
            if ((m_st == 1 || m_st == 5) && m_raw && !cs_n) m_fault = 1;
            if (!acc) m_csq = 1;
            else if (!p) begin
                if (cs_n) m_csq = 1;
                else if (m_csq && m_raw) m_csq = 0;
            end
            if (!p) m_sck = sck;
            m_raw = cs_n; m_st = ns; m_left = nl;
        end
    end

    // Per-cycle comparison, sampled away from the edge.
    always @(posedge clk) begin
        #2;
        if (m_ok && !done) begin
            bit ep;
            ep = !hold_n && !m_csq;
            chk("R2 bus_en",      bus_en,     (m_st >= 2 && m_st <= 4));
            chk("R4 regs_on",     regs_on,    (m_st != 0 && m_st != 4));
            chk("R5 cmd_lock",    cmd_lock,   (m_st == 3 || m_st == 4));
            chk("R10 cs_fwd_n",   cs_fwd_n,   m_csq);
            chk("R9 sck_fwd",     sck_fwd,    m_sck);
            chk("R7 xfer_pause",  xfer_pause, ep);
            chk("R7 so_hiz",      so_hiz,     ep || m_csq);
            chk("R3 fault",       fault,      m_fault);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sleep();
        sleep_cmd = 1'b1; step(1); sleep_cmd = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_cmd = 1'b1; step(1); wake_cmd = 1'b0;
    endtask

    initial begin
        rst_n = 0; pwr_good = 0; cs_n = 1; sck = 0; hold_n = 1;
        sleep_cmd = 0; wake_cmd = 0;
        step(3); rst_n = 1; step(2);
        chk("R1 bus_en", bus_en, 0);     chk("R1 regs_on", regs_on, 0);
        chk("R1 cs_fwd_n", cs_fwd_n, 1); chk("R1 so_hiz", so_hiz, 1);
        chk("R1 fault", fault, 0);       chk("R1 cmd_lock", cmd_lock, 0);

        // R10: chip select parked low across the end of the start-up lockout.
        cs_n = 0; step(2); pwr_good = 1;
        step(BOOT - 2);
        chk("R2 bus_en in lockout", bus_en, 0);
        step(4);
        chk("R2 bus_en after lockout", bus_en, 1);
        chk("R10 held-low cs not forwarded", cs_fwd_n, 1);
        chk("R10 no fault", fault, 0);
        cs_n = 1; step(2); cs_n = 0; step(2);
        chk("R10 true fall forwarded", cs_fwd_n, 0);

        // R7/R9: hold inside a live transfer.
        for (int i = 0; i < 6; i++) begin sck = ~sck; step(1); end
        hold_n = 0;
        for (int i = 0; i < 4; i++) begin sck = ~sck; step(1); end
        chk("R7 pause", xfer_pause, 1);
        chk("R7 so_hiz", so_hiz, 1);
        cs_n = 1; step(2);
        chk("R7 cs frozen", cs_fwd_n, 0);
        cs_n = 0; hold_n = 1; step(1);
        for (int i = 0; i < 4; i++) begin sck = ~sck; step(1); end
        chk("R9 resumed", xfer_pause, 0);

        // R8: hold outside a transfer.
        cs_n = 1; step(2); hold_n = 0; sck = ~sck; step(2);
        chk("R8 no pause", xfer_pause, 0);
        chk("R8 sck follows", sck_fwd, sck);
        hold_n = 1; step(1);

        // R5: wake while running is ignored.
        pulse_wake(); step(2);
        chk("R5 wake ignored bus_en", bus_en, 1);
        chk("R5 wake ignored lock", cmd_lock, 0);

        // R4: sleep entry then sleep.
        pulse_sleep(); step(1);
        chk("R4 entering lock", cmd_lock, 1);
        chk("R4 regs still on", regs_on, 1);
        pulse_sleep();
        step(DOZE + 2);
        chk("R4 regs off", regs_on, 0);
        pulse_sleep(); step(2);
        chk("R5 sleep in sleep ignored", regs_on, 0);
        chk("R5 lock kept", cmd_lock, 1);

        // R6/R3: wake recovery with a chip-select drop.
        pulse_wake(); step(2);
        chk("R6 recovery bus_en", bus_en, 0);
        chk("R6 recovery regs_on", regs_on, 1);
        cs_n = 0; step(2); cs_n = 1;
        chk("R3 fault set in recovery", fault, 1);
        chk("R6 cs blocked", cs_fwd_n, 1);
        step(WAKE);
        chk("R6 running again", bus_en, 1);

        // R6: wake during sleep entry.
        pulse_sleep(); step(2); pulse_wake(); step(2);
        chk("R6 early wake regs", regs_on, 1);
        chk("R6 early wake bus", bus_en, 0);
        step(WAKE + 2);
        chk("R6 early wake done", bus_en, 1);

        // R11: power loss mid-transfer.
        cs_n = 0; step(2); pwr_good = 0; step(2);
        chk("R11 bus_en", bus_en, 0); chk("R11 regs_on", regs_on, 0);
        chk("R11 cs_fwd_n", cs_fwd_n, 1);
        chk("R3 fault survives power loss", fault, 1);

        // R3: reset clears, then a fall in the start-up lockout.
        cs_n = 1; rst_n = 0; step(2); rst_n = 1; step(1);
        chk("R3 fault cleared by reset", fault, 0);
        pwr_good = 1; step(5); cs_n = 0; step(2);
        chk("R3 fault in start-up", fault, 1);
        chk("R3 cs blocked in start-up", cs_fwd_n, 1);
        cs_n = 1; step(BOOT);
        chk("R2 running after second boot", bus_en, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog (all) actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule